// File: doc/BRIEF.md
# Periodic Delay-Table Sequencer

This block replays a table of delay codes in an endless loop. Its output drives a programmable delay element on a clock path, so the clock edge timing moves in a deterministic, periodic way and a known jitter waveform is imposed on that clock. A host fills the table through a write port, then strobes load-done to arm playback. Each pulse of a tick-enable (a 50 MHz update rate, one entry per 20 ns) presents the next entry. After the last entry the sequence returns to the first and repeats. With the full 13-bit address (8192 entries) one pass lasts 163.84 µs. The fundamental of any jitter waveform played this way is therefore about 6104 Hz or an integer multiple of it. The default build uses a smaller table so that it elaborates quickly; production sets `ADDR_W` to 13.

Each host word is a signed number of 10 ps steps above the minimum delay of 2.2 ns. The element covers 2.2 ns to 12.2 ns, so legal codes are 0 to 1000. Words outside that span are clamped to the nearest bound before they reach the output.

Control is a three-state machine. LOAD is the reset state, and table writes are accepted only there. LOAD goes to ARMED on load-done. ARMED goes to PLAY on the first tick, and PLAY stays in PLAY. Reset returns every state to LOAD. Once the machine leaves LOAD, the table is frozen until the next reset.

Top module: `jitter_table_player`

## Requirements
- R1: While reset is asserted and in the first cycle after it, delay_code is 0, code_index is 0, and code_strobe, playing and armed are all 0.
- R2: A signed word v written to the table is stored and later presented as 0 when v < 0, as 1000 when v > 1000, and as v otherwise. delay_code never exceeds 1000.
- R3: In LOAD, wr_addr_we loads the write pointer from wr_addr, and wr_data_we writes at the pointer and then advances it by one, modulo the table depth. When both are high in the same cycle, the word goes to wr_addr and the pointer becomes wr_addr+1.
- R4: load_done in LOAD raises armed in the next cycle. armed and playing are never both high, and armed rises only after load_done.
- R5: The first tick in ARMED makes, one cycle later, code_index 0, delay_code the entry at index 0, code_strobe 1, playing 1 and armed 0.
- R6: In PLAY each tick presents the next entry one cycle later and pulses code_strobe for that one cycle. Without a tick, delay_code and code_index hold and code_strobe is 0.
- R7: After the entry at index DEPTH-1, the next tick presents index 0. Playback repeats without end.
- R8: Writes to the table in ARMED or PLAY are ignored: later playback shows the table as it was loaded.
- R9: Reset during playback stops it, returns code_index and the write pointer to 0, and re-opens table writes, so that a new table can be loaded and played.
- R10: load_done outside LOAD has no effect. Ticks in LOAD produce no code_strobe and leave delay_code at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Update-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per update tick from a divider |
| wr_addr_we | input | 1 | Load the write pointer from wr_addr |
| wr_addr | input | ADDR_W | Write pointer value |
| wr_data_we | input | 1 | Write wr_data at the pointer and advance it |
| wr_data | input | DIN_W | Signed delay word in 10 ps steps |
| load_done | input | 1 | Table complete; arm playback |
| delay_code | output | CODE_W | Registered step index for the delay element |
| code_index | output | ADDR_W | Table index of the code on delay_code |
| code_strobe | output | 1 | High for the cycle in which a new code appears |
| playing | output | 1 | Machine is in PLAY |
| armed | output | 1 | Machine is in ARMED |

## Verification
The assertions assume that tick_en pulses are synchronous to clk and that load_done and the write strobes are driven only between resets in the order load, then arm. Nothing is assumed about tick spacing, so ticks may come back to back or be spread out. The stimulus fills every table entry before arming, so playback never reads an unwritten entry. Ticks arrive with a random density, and write or load-done pulses are thrown in at random while playing to show that they are ignored. Directed entries at -32768, -1, 0, 1000, 1001 and 32767 exercise the clamp at both bounds, and a reset in the middle of playback is followed by a second table that differs from the first.

// File: rtl/jtp_pkg.sv
package jtp_pkg;

    // Sequencer control states
    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,   // table open for writes
        ST_ARMED = 2'd1,   // table frozen, waiting for first tick
        ST_PLAY  = 2'd2    // free-running replay
    } play_state_e;

endpackage

// File: rtl/jtp_clamp.sv
// Limits a signed host word to the legal code span 0..CODE_MAX.
module jtp_clamp #(
    parameter int DIN_W    = 16,
    parameter int CODE_W   = 10,
    parameter int CODE_MAX = 1000
) (
    input  logic signed [DIN_W-1:0]  din,
    output logic        [CODE_W-1:0] code
);

    localparam logic signed [DIN_W-1:0] MAX_S    = DIN_W'(CODE_MAX);
    localparam logic        [CODE_W-1:0] MAX_CODE = CODE_W'(CODE_MAX);

    always_comb begin
        if (din[DIN_W-1]) begin
            code = '0;
        end else if (din > MAX_S) begin
            code = MAX_CODE;
        end else begin
            code = din[CODE_W-1:0];
        end
    end

endmodule

// File: rtl/jtp_table.sv
// Code storage with an auto-advancing write pointer.
module jtp_table #(
    parameter int ADDR_W = 11,
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_open,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              data_we,
    input  logic [CODE_W-1:0] code_in,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CODE_W-1:0] rd_code
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [CODE_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] target;

    // A same-cycle address load redirects the data write.
    assign target = addr_we ? addr : wr_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (wr_open) begin
            if (data_we) begin
                wr_ptr <= target + ADDR_W'(1);
            end else if (addr_we) begin
                wr_ptr <= addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_open && data_we) begin
            mem[target] <= code_in;
        end
    end

    assign rd_code = mem[rd_addr];

endmodule

// File: rtl/jtp_ctrl.sv
// Control state machine and replay address counter.
module jtp_ctrl #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              load_done,
    output logic              wr_open,
    output logic              fetch,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              armed,
    output logic              playing
);

    import jtp_pkg::*;

    play_state_e       st_q;
    play_state_e       st_nxt;
    logic [ADDR_W-1:0] play_addr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_LOAD;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Transitions
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_LOAD:  if (load_done) st_nxt = ST_ARMED;
            ST_ARMED: if (tick_en)   st_nxt = ST_PLAY;
            ST_PLAY:  st_nxt = ST_PLAY;
            default:  st_nxt = ST_LOAD;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        wr_open = 1'b0;
        fetch   = 1'b0;
        armed   = 1'b0;
        playing = 1'b0;
        unique case (st_q)
            ST_LOAD:  wr_open = 1'b1;
            ST_ARMED: begin
                armed = 1'b1;
                fetch = tick_en;
            end
            ST_PLAY: begin
                playing = 1'b1;
                fetch   = tick_en;
            end
            default: wr_open = 1'b0;
        endcase
    end

    // Replay address: held at zero until the first fetch, wraps by width.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            play_addr <= '0;
        end else if (fetch) begin
            play_addr <= play_addr + ADDR_W'(1);
        end
    end

    assign rd_addr = play_addr;

endmodule

// File: rtl/jtp_out.sv
// Output register: code, its index and a one-cycle update strobe.
module jtp_out #(
    parameter int ADDR_W = 11,
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CODE_W-1:0] rd_code,
    output logic [CODE_W-1:0] delay_code,
    output logic [ADDR_W-1:0] code_index,
    output logic              code_strobe
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            delay_code  <= '0;
            code_index  <= '0;
            code_strobe <= 1'b0;
        end else begin
            code_strobe <= fetch;
            if (fetch) begin
                delay_code <= rd_code;
                code_index <= rd_addr;
            end
        end
    end

endmodule

// File: rtl/jitter_table_player.sv
module jitter_table_player #(
    parameter int ADDR_W   = 11,
    parameter int DIN_W    = 16,
    parameter int CODE_W   = 10,
    parameter int CODE_MAX = 1000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_en,
    input  logic                    wr_addr_we,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic                    wr_data_we,
    input  logic signed [DIN_W-1:0] wr_data,
    input  logic                    load_done,
    output logic [CODE_W-1:0]       delay_code,
    output logic [ADDR_W-1:0]       code_index,
    output logic                    code_strobe,
    output logic                    playing,
    output logic                    armed
);

    logic              wr_open;
    logic              fetch;
    logic [ADDR_W-1:0] rd_addr;
    logic [CODE_W-1:0] rd_code;
    logic [CODE_W-1:0] wr_code;

    jtp_clamp #(.DIN_W(DIN_W), .CODE_W(CODE_W), .CODE_MAX(CODE_MAX)) u_clamp (
        .din  (wr_data),
        .code (wr_code)
    );

    jtp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .load_done (load_done),
        .wr_open   (wr_open),
        .fetch     (fetch),
        .rd_addr   (rd_addr),
        .armed     (armed),
        .playing   (playing)
    );

    jtp_table #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_open (wr_open),
        .addr_we (wr_addr_we),
        .addr    (wr_addr),
        .data_we (wr_data_we),
        .code_in (wr_code),
        .rd_addr (rd_addr),
        .rd_code (rd_code)
    );

    jtp_out #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch       (fetch),
        .rd_addr     (rd_addr),
        .rd_code     (rd_code),
        .delay_code  (delay_code),
        .code_index  (code_index),
        .code_strobe (code_strobe)
    );

endmodule

// File: rtl/jtp_checker.sv
module jtp_checker #(
    parameter int ADDR_W   = 11,
    parameter int CODE_W   = 10,
    parameter int CODE_MAX = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              load_done,
    input logic [CODE_W-1:0] delay_code,
    input logic [ADDR_W-1:0] code_index,
    input logic              code_strobe,
    input logic              playing,
    input logic              armed
);

    assert_code_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        delay_code <= CODE_W'(CODE_MAX));

    assert_states_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed && playing));

    assert_arm_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(load_done));

    assert_first_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(playing) |-> (code_index == '0) && code_strobe);

    assert_strobe_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        code_strobe |-> $past(tick_en));

    assert_hold_between_ticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !code_strobe |-> $stable(delay_code) && $stable(code_index));

    assert_next_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (code_strobe && $past(playing)) |-> code_index == ADDR_W'($past(code_index) + 1'b1));

    assert_idle_while_loading_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !playing) |-> !code_strobe);

endmodule

bind jitter_table_player jtp_checker #(
    .ADDR_W   (ADDR_W),
    .CODE_W   (CODE_W),
    .CODE_MAX (CODE_MAX)
) u_jtp_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .load_done   (load_done),
    .delay_code  (delay_code),
    .code_index  (code_index),
    .code_strobe (code_strobe),
    .playing     (playing),
    .armed       (armed)
);

// File: tb/tb_jitter_table_player.sv
module tb_jitter_table_player;

    localparam int CLK_PERIOD = 20;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_en = 1'b0;
    logic              wr_addr_we = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic              wr_data_we = 1'b0;
    logic signed [15:0] wr_data = '0;
    logic              load_done = 1'b0;
    logic [9:0]        delay_code;
    logic [AW-1:0]     code_index;
    logic              code_strobe;
    logic              playing;
    logic              armed;

    jitter_table_player #(.ADDR_W(AW)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .wr_addr_we  (wr_addr_we),
        .wr_addr     (wr_addr),
        .wr_data_we  (wr_data_we),
        .wr_data     (wr_data),
        .load_done   (load_done),
        .delay_code  (delay_code),
        .code_index  (code_index),
        .code_strobe (code_strobe),
        .playing     (playing),
        .armed       (armed)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int  n_checks = 0;
    int  n_err    = 0;
    bit  finished = 1'b0;
    bit  rst_req  = 1'b1;

    // Reference model, kept from the requirements
    int tbl [DEPTH];
    int wptr, mst, midx, nidx, mcode;
    bit mstb;

    function automatic int clamp_ref(int v);
        if (v < 0) return 0;
        if (v > 1000) return 1000;
        return v;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        wptr = 0; mst = 0; midx = 0; nidx = 0; mcode = 0; mstb = 0;
    endtask

    // One clock: drive at negedge, update model at posedge, compare after it.
    task automatic cyc(string ph, bit tk, bit aw, int ad, bit dw, int dv, bit ld);
        int t;
        @(negedge clk);
        rst_n      = !rst_req;
        tick_en    = tk;
        wr_addr_we = aw;
        wr_addr    = ad[AW-1:0];
        wr_data_we = dw;
        wr_data    = dv[15:0];
        load_done  = ld;
        @(posedge clk);
        if (rst_req) begin
            model_reset();
        end else begin
            mstb = 0;
            case (mst)
                0: begin
                    t = aw ? (ad % DEPTH) : wptr;
                    if (dw) begin
                        tbl[t] = clamp_ref(int'($signed(dv[15:0])));
                        wptr = (t + 1) % DEPTH;
                    end else if (aw) begin
                        wptr = t;
                    end
                    if (ld) mst = 1;
                end
                1: if (tk) begin
                    midx = 0; mcode = tbl[0]; nidx = 1; mstb = 1; mst = 2;
                end
                default: if (tk) begin
                    midx = nidx; mcode = tbl[nidx]; nidx = (nidx + 1) % DEPTH; mstb = 1;
                end
            endcase
        end
        #1;
        chk({ph, " code"},    int'(delay_code),  mcode);
        chk({ph, " index"},   int'(code_index),  midx);
        chk({ph, " strobe"},  int'(code_strobe), int'(mstb));
        chk({ph, " armed"},   int'(armed),       int'(mst == 1));
        chk({ph, " playing"}, int'(playing),     int'(mst == 2));
    endtask

    function automatic int rnd_word();
        return int'($urandom_range(0, 4000)) - 1500;
    endfunction

    task automatic fill_table(string ph);
        for (int i = 0; i < DEPTH; i++) begin
            cyc(ph, 1'b0, (i == 0), 0, 1'b1, rnd_word(), 1'b0);
        end
        // Directed clamp corners written by address jumps (R2, R3)
        cyc({ph, " R2"}, 1'b0, 1'b1, 5,  1'b1, -1,     1'b0);
        cyc({ph, " R2"}, 1'b0, 1'b0, 0,  1'b1, 1001,   1'b0);
        cyc({ph, " R2"}, 1'b0, 1'b1, 20, 1'b1, -32768, 1'b0);
        cyc({ph, " R2"}, 1'b0, 1'b0, 0,  1'b1, 32767,  1'b0);
        cyc({ph, " R2"}, 1'b0, 1'b1, 40, 1'b1, 1000,   1'b0);
        cyc({ph, " R2"}, 1'b0, 1'b0, 0,  1'b1, 0,      1'b0);
        // Pointer wrap at the top of the table (R3)
        cyc({ph, " R3"}, 1'b0, 1'b1, DEPTH-1, 1'b0, 0, 1'b0);
        cyc({ph, " R3"}, 1'b0, 1'b0, 0, 1'b1, 777, 1'b0);
        cyc({ph, " R3"}, 1'b0, 1'b0, 0, 1'b1, 333, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd90417));
        model_reset();
        // R1: reset state
        rst_req = 1'b1;
        cyc("R1 reset", 1'b0, 1'b0, 0, 1'b0, 0, 1'b0);
        cyc("R1 reset", 1'b1, 1'b0, 0, 1'b0, 0, 1'b0);
        rst_req = 1'b0;
        cyc("R1 after reset", 1'b0, 1'b0, 0, 1'b0, 0, 1'b0);

        fill_table("R3 fill");
        // R10: ticks while loading produce nothing
        for (int i = 0; i < 4; i++) cyc("R10 tick in load", 1'b1, 1'b0, 0, 1'b0, 0, 1'b0);
        // R4: arm
        cyc("R4 arm", 1'b0, 1'b0, 0, 1'b0, 0, 1'b1);
        // R8 and R10: writes and load_done while armed are ignored
        cyc("R8 write armed", 1'b0, 1'b1, 0, 1'b1, 500, 1'b1);
        cyc("R8 write armed", 1'b0, 1'b0, 0, 1'b1, 600, 1'b0);
        // R5: first tick
        cyc("R5 first tick", 1'b1, 1'b0, 0, 1'b0, 0, 1'b0);
        // R6, R7, R8: random replay over several passes
        for (int i = 0; i < 400; i++) begin
            bit tk;
            tk = ($urandom_range(0, 9) < 7);
            cyc("R6 R7 R8 replay", tk, $urandom_range(0, 7) == 0, int'($urandom_range(0, DEPTH-1)),
                $urandom_range(0, 5) == 0, rnd_word(), $urandom_range(0, 9) == 0);
        end
        // Back-to-back ticks across the wrap (R7)
        for (int i = 0; i < DEPTH + 3; i++) cyc("R7 dense", 1'b1, 1'b0, 0, 1'b0, 0, 1'b0);

        // R9: reset mid-play, load a new table, replay
        rst_req = 1'b1;
        cyc("R9 reset in play", 1'b1, 1'b0, 0, 1'b0, 0, 1'b0);
        rst_req = 1'b0;
        cyc("R9 after reset", 1'b0, 1'b0, 0, 1'b0, 0, 1'b0);
        fill_table("R9 refill");
        cyc("R9 arm", 1'b0, 1'b0, 0, 1'b0, 0, 1'b1);
        for (int i = 0; i < 200; i++) begin
            cyc("R9 replay", $urandom_range(0, 1) == 1, 1'b0, 0, 1'b0, 0, 1'b0);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule